// File: doc/BRIEF.md
# TI-Frame Serial Slave with MISO Hold

This block is the receive and transmit engine of a synchronous serial slave that uses the TI frame format. An external master supplies the serial clock and a one-bit-wide frame pulse. The slave shifts a byte in on the data input and a byte out on the data output, both most significant bit first. Outgoing bits change on rising clock edges and incoming bits are sampled on falling clock edges. All pin inputs are synchronized into the local pclk domain, and edges are detected there.

When the last bit of a frame has been sampled, the slave does not release its data output at once. It keeps the final bit on the line for a hold window whose length depends on a 3-bit prescaler setting, then drops the output enable. A frame pulse that arrives while a byte is still in progress is illegal. It sets a sticky frame-error flag, which the local logic clears with a one-cycle pulse. The local logic hands over outgoing bytes through a valid/ready handshake and receives incoming bytes through a one-cycle valid strobe.

Top module: `tis_slave`

## Requirements
- R1: After reset, miso_oe_o, miso_o, rx_valid_o and ferr_o are 0 and tx_ready_o is 1.
- R2: In a frame, the eight falling SCK edges after the frame pulse sample MOSI MSB first. After the eighth one, rx_data_o holds the byte and rx_valid_o is high for exactly one pclk cycle.
- R3: A high NSS seen at a falling SCK edge while idle arms a frame. The next rising edge drives bit 7 of the outgoing byte on miso_o with miso_oe_o high, and each of the following seven rising edges drives the next lower bit.
- R4: A byte is accepted when tx_valid_i and tx_ready_o are both high. tx_ready_o then stays low until a frame start consumes the byte. tx_valid_i is ignored while tx_ready_o is low, so the held byte is the one transmitted.
- R5: A frame that starts with no byte held transmits 0x00.
- R6: miso_oe_o stays high after the final sample. It falls exactly 2^psc_i + 5 pclk cycles after the cycle in which rx_valid_o rises; for psc_i = 2 that is 9 cycles. The count is measured in the pclk domain from the synchronized falling edge.
- R7: A high NSS at the eighth falling edge of a frame starts the next frame directly. MISO is not released between the two frames and no frame error is raised.
- R8: A high NSS at any of the first seven falling edges of a frame sets ferr_o. The frame still completes and delivers its byte.
- R9: ferr_o stays set until a one-cycle ferr_clr_i pulse clears it. A new error in the same cycle takes priority over the clear.
- R10: SCK edges without a preceding frame pulse neither enable MISO nor produce rx_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pclk |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psc_i | input | 3 | Prescaler code, bit time = 2^(psc_i+1) pclk |
| sck_i | input | 1 | Serial clock from master |
| nss_i | input | 1 | Frame pulse from master |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for MISO pad |
| tx_valid_i | input | 1 | Outgoing byte offered |
| tx_data_i | input | 8 | Outgoing byte |
| tx_ready_o | output | 1 | Transmit holding register empty |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| ferr_o | output | 1 | Sticky frame-error flag |
| ferr_clr_i | input | 1 | Clears ferr_o |

## Verification
The checker watches several properties on every cycle. It checks that the receive strobe lasts one cycle and that the output is still driven when a byte lands. It also checks that every release of MISO comes exactly 2^psc + 5 cycles after the last strobe, that the error flag only falls after a clear, and that an accepted transmit byte drops ready. Other behaviour can only be shown by the bench's scenarios: the bit order on both data lines, the 0x00 fill, the rejection of a second byte, chained frames keeping the pin driven, error injection at a mid-byte edge, and clock activity with no frame pulse.

// File: rtl/tis_pkg.sv
package tis_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_ARMED = 2'd1,
    FR_SHIFT = 2'd2
  } fr_state_e;
endpackage

// File: rtl/tis_sync.sv
module tis_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tis_frame.sv
module tis_frame
  import tis_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              nss_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              start_o,
  output logic              done_o,
  output logic              ferr_evt_o,
  output logic              miso_bit_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int unsigned     CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  fr_state_e         state_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_bit;

  assign last_bit   = (state_q == FR_SHIFT) && (cnt_q == LAST);
  assign start_o    = sck_rise_i && (state_q == FR_ARMED);
  assign done_o     = sck_fall_i && last_bit;
  // frame pulse inside a byte is illegal; on the last bit it chains
  assign ferr_evt_o = sck_fall_i && nss_i && (state_q == FR_SHIFT) && !last_bit;
  assign miso_bit_o = tx_sh_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= FR_IDLE;
      tx_sh_q    <= '0;
      rx_sh_q    <= '0;
      cnt_q      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (sck_fall_i) begin
        if (state_q == FR_SHIFT) begin
          rx_sh_q <= {rx_sh_q[DATA_W-2:0], mosi_i};
          cnt_q   <= cnt_q + 1'b1;
        end
        if (last_bit) begin
          rx_data_o  <= {rx_sh_q[DATA_W-2:0], mosi_i};
          rx_valid_o <= 1'b1;
          cnt_q      <= '0;
        end
        if (nss_i && (state_q == FR_IDLE || last_bit)) state_q <= FR_ARMED;
        else if (last_bit)                             state_q <= FR_IDLE;
      end else if (sck_rise_i) begin
        if (state_q == FR_ARMED) begin
          state_q <= FR_SHIFT;
          tx_sh_q <= tx_byte_i;
          cnt_q   <= '0;
        end else if (state_q == FR_SHIFT) begin
          tx_sh_q <= tx_sh_q << 1;
        end
      end
    end
  end
endmodule

// File: rtl/tis_hold.sv
module tis_hold #(
  parameter int unsigned PSC_W      = 3,
  parameter int unsigned HOLD_EXTRA = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             start_i,
  input  logic             done_i,
  output logic             drive_o
);
  localparam int unsigned HOLD_MAX = (1 << ((1 << PSC_W) - 1)) + HOLD_EXTRA;
  localparam int unsigned CW       = $clog2(HOLD_MAX + 1);

  logic [CW-1:0] cnt_q, load_val;

  // half bit time plus fixed margin
  assign load_val = (CW'(1) << psc_i) + CW'(HOLD_EXTRA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      drive_o <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= '0;
      drive_o <= 1'b1;
    end else if (done_i) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) drive_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tis_slave.sv
module tis_slave #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PSC_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_EXTRA  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic              sck_i,
  input  logic              nss_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              ferr_o,
  input  logic              ferr_clr_i
);
  logic [2:0]        pin_s;
  logic              sck_s, nss_s, mosi_s, sck_q;
  logic              sck_rise, sck_fall;
  logic              start, done, ferr_evt, miso_bit, drive;
  logic              tx_full_q;
  logic [DATA_W-1:0] tx_buf_q, tx_byte;

  tis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({nss_i, mosi_i, sck_i}),
    .q_o   (pin_s)
  );
  assign {nss_s, mosi_s, sck_s} = pin_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  // transmit holding register
  assign tx_ready_o = ~tx_full_q;
  assign tx_byte    = tx_full_q ? tx_buf_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_full_q <= 1'b0;
      tx_buf_q  <= '0;
    end else if (tx_valid_i && tx_ready_o) begin
      tx_full_q <= 1'b1;
      tx_buf_q  <= tx_data_i;
    end else if (start) begin
      tx_full_q <= 1'b0;
    end
  end

  tis_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall),
    .nss_i     (nss_s),
    .mosi_i    (mosi_s),
    .tx_byte_i (tx_byte),
    .start_o   (start),
    .done_o    (done),
    .ferr_evt_o(ferr_evt),
    .miso_bit_o(miso_bit),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o)
  );

  tis_hold #(.PSC_W(PSC_W), .HOLD_EXTRA(HOLD_EXTRA)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .psc_i  (psc_i),
    .start_i(start),
    .done_i (done),
    .drive_o(drive)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       ferr_o <= 1'b0;
    else if (ferr_evt) ferr_o <= 1'b1;
    else if (ferr_clr_i) ferr_o <= 1'b0;

  assign miso_oe_o = drive;
  assign miso_o    = drive & miso_bit;
endmodule

// File: rtl/tis_slave_chk.sv
module tis_slave_chk #(
  parameter int unsigned PSC_W      = 3,
  parameter int unsigned HOLD_EXTRA = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PSC_W-1:0] psc_i,
  input logic             miso_oe_o,
  input logic             rx_valid_o,
  input logic             tx_valid_i,
  input logic             tx_ready_o,
  input logic             ferr_o,
  input logic             ferr_clr_i
);
  logic [15:0] since_rx_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 since_rx_q <= '0;
    else if (rx_valid_o)         since_rx_q <= 16'd1;
    else if (since_rx_q != '0 && since_rx_q != 16'hffff)
                                 since_rx_q <= since_rx_q + 16'd1;

  always @(posedge clk_i)
    if (!rst_ni) a_r1_quiet_in_reset: assert (!miso_oe_o && !rx_valid_o && !ferr_o && tx_ready_o);

  a_r2_rx_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r6_driven_at_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> miso_oe_o);

  a_r6_release_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(miso_oe_o) |-> (32'(since_rx_q) == ((32'd1 << psc_i) + 32'(HOLD_EXTRA))));

  a_r9_ferr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ferr_o) |-> $past(ferr_clr_i));

  a_r4_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);
endmodule

bind tis_slave tis_slave_chk #(.PSC_W(PSC_W), .HOLD_EXTRA(HOLD_EXTRA)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psc_i     (psc_i),
  .miso_oe_o (miso_oe_o),
  .rx_valid_o(rx_valid_o),
  .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o),
  .ferr_o    (ferr_o),
  .ferr_clr_i(ferr_clr_i)
);

// File: tb/tb_tis_slave.sv
module tb_tis_slave;
  localparam int H = 6;  // pclk cycles per SCK half period

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] psc = 3'd2;
  logic       sck = 1'b0, nss = 1'b0, mosi = 1'b0;
  logic       miso, miso_oe, tx_valid = 1'b0, tx_ready, rx_valid, ferr, ferr_clr = 1'b0;
  logic [7:0] tx_data = '0, rx_data;

  int checks = 0, fails = 0, cyc = 0, rx_seen = 0, rx_cyc = 0, oe_falls = 0, oe_fall_cyc = 0;
  logic [7:0] rx_last = '0;
  logic       oe_prev = 1'b0;

  always #10 clk = ~clk;

  tis_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .psc_i(psc), .sck_i(sck), .nss_i(nss), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .ferr_o(ferr),
    .ferr_clr_i(ferr_clr)
  );

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rx_valid) begin rx_seen++; rx_last = rx_data; rx_cyc = cyc; end
    if (oe_prev && !miso_oe) begin oe_falls++; oe_fall_cyc = cyc; end
    oe_prev = miso_oe;
  end

  typedef struct packed {
    logic [7:0] tx;
    logic       has_tx;
    logic [7:0] mosi;
    logic [2:0] psc;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hA5, 1'b1, 8'h3C, 3'd2},
    '{8'h01, 1'b1, 8'h80, 3'd0},
    '{8'hFF, 1'b1, 8'h00, 3'd7},
    '{8'h00, 1'b0, 8'hC3, 3'd3},
    '{8'h96, 1'b1, 8'h69, 3'd1},
    '{8'h7E, 1'b1, 8'hFF, 3'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_push(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // ferr_at: bit index whose falling edge sees NSS high (-1 none)
  task automatic do_frame(input logic [7:0] mb, input int ferr_at, input bit chain,
                          input bit pulse, input bit push_nxt, input logic [7:0] nxt,
                          output logic [7:0] mo, output bit oe_all);
    oe_all = 1'b1;
    if (pulse) begin
      @(negedge clk); sck = 1'b1; nss = 1'b1; wait_n(H);
      sck = 1'b0; wait_n(H);
    end
    for (int i = 0; i < 8; i++) begin
      sck = 1'b1; mosi = mb[7-i];
      nss = (i == ferr_at) || (i == 7 && chain);
      if (i == 2 && push_nxt) tx_push(nxt);
      wait_n(H);
      mo[7-i] = miso;
      if (!miso_oe) oe_all = 1'b0;
      sck = 1'b0; wait_n(H);
    end
    nss = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] m, m2;
    bit         ok, ok2;
    int         rs, fs;

    wait_n(3);
    // R1 reset state
    chk("R1 oe", miso_oe, 0);
    chk("R1 miso", miso, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 ferr", ferr, 0);
    chk("R1 tx_ready", tx_ready, 1);
    rst_n = 1'b1;
    wait_n(4);

    // R10 clock activity without frame pulse
    rs = rx_seen; ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sck = 1'b1; mosi = i[0]; wait_n(H); if (miso_oe) ok = 1'b0;
      sck = 1'b0; wait_n(H); if (miso_oe) ok = 1'b0;
    end
    wait_n(10);
    chk("R10 no drive", ok, 1);
    chk("R10 no rx", rx_seen, rs);

    // vector table: R2 R3 R5 R6
    for (int v = 0; v < 6; v++) begin
      psc = VECS[v].psc;
      if (VECS[v].has_tx) tx_push(VECS[v].tx);
      rs = rx_seen; fs = oe_falls;
      do_frame(VECS[v].mosi, -1, 1'b0, 1'b1, 1'b0, 8'h00, m, ok);
      wait_n(160);
      chk("R3 miso byte", m, VECS[v].has_tx ? VECS[v].tx : 8'h00);
      chk("R3 oe during bits", ok, 1);
      chk("R2 rx count", rx_seen, rs + 1);
      chk("R2 rx byte", rx_last, VECS[v].mosi);
      chk("R6 release count", oe_falls, fs + 1);
      chk("R6 hold cycles", oe_fall_cyc - rx_cyc, (1 << VECS[v].psc) + 5);
    end

    // R4 second offer ignored while full, R5 empty sends zero
    psc = 3'd2;
    tx_push(8'h3C);
    wait_n(1);
    chk("R4 ready low", tx_ready, 0);
    tx_push(8'hF0);
    do_frame(8'h11, -1, 1'b0, 1'b1, 1'b0, 8'h00, m, ok);
    wait_n(40);
    chk("R4 held byte sent", m, 8'h3C);
    chk("R4 ready back", tx_ready, 1);
    do_frame(8'h22, -1, 1'b0, 1'b1, 1'b0, 8'h00, m, ok);
    wait_n(40);
    chk("R5 zero fill", m, 8'h00);

    // R7 chained frames
    tx_push(8'h81);
    rs = rx_seen; fs = oe_falls;
    do_frame(8'hE7, -1, 1'b1, 1'b1, 1'b1, 8'h5A, m, ok);
    do_frame(8'h18, -1, 1'b0, 1'b0, 1'b0, 8'h00, m2, ok2);
    wait_n(4);
    chk("R7 first byte", m, 8'h81);
    chk("R7 second byte", m2, 8'h5A);
    chk("R7 no release", oe_falls, fs);
    chk("R7 no ferr", ferr, 0);
    chk("R7 rx both", rx_seen, rs + 2);
    chk("R7 rx second", rx_last, 8'h18);
    wait_n(40);

    // R8 mid-byte pulse, R9 sticky and clear
    rs = rx_seen;
    do_frame(8'h4D, 3, 1'b0, 1'b1, 1'b0, 8'h00, m, ok);
    wait_n(40);
    chk("R8 ferr set", ferr, 1);
    chk("R8 frame completes", rx_seen, rs + 1);
    chk("R8 rx byte", rx_last, 8'h4D);
    wait_n(50);
    chk("R9 sticky", ferr, 1);
    @(negedge clk); ferr_clr = 1'b1;
    @(negedge clk); ferr_clr = 1'b0;
    wait_n(2);
    chk("R9 cleared", ferr, 0);

    report();
  end
endmodule